// File: doc/BRIEF.md
# Grayscale Clock Burst Sequencer

This block generates the grayscale clock for a time-multiplexed LED driver that scans 32 address lines. During each line it emits a burst of exactly 257 grayscale pulses. Each pulse is one period of a slow pulse clock, derived by dividing the system clock by `DIV_N`. After the burst the grayscale output stays low for an idle gap. The gap length is a count of system clocks from an input, so it does not depend on the pulse rate. With a 250 MHz system clock, `DIV_N` = 125 gives the 2 MHz pulse clock, and a gap of 375 to 625 clocks gives 1.5 to 2.5 µs.

The line address is a binary code. It steps once per line, at the moment the burst ends, so it is always settled before the next burst starts. A one-cycle line-advance strobe marks each step. When the last line finishes, a one-cycle end-of-frame pulse tells the surrounding logic to issue the driver's frame-sync command. Dropping the enable stops the scan cleanly. Raising it again restarts the scan from line 0.

Top module: `gs_burst_seq`

## Requirements
- R1: While enabled, each line burst holds exactly 257 pulses. Each pulse lasts `DIV_N` system clocks: high for the first `DIV_N/2` and low for the rest. The first pulse goes high in the cycle after the burst begins.
- R2: After the 257th pulse ends, `gs_clk_o` stays low for G system clocks. G is `gap_len_i` sampled at the clock edge that ends the burst, with 0 treated as 1. The next burst then starts.
- R3: `addr_o` is a 5-bit binary line number in the range 0..31. It increments at the clock edge that ends a burst and wraps from 31 to 0. It never changes while a burst is in progress.
- R4: `line_adv_o` is high for exactly one cycle, the first gap cycle after each completed burst, and is low otherwise.
- R5: `eof_o` is high for one cycle together with `line_adv_o` when line 31 completes, which is the cycle `addr_o` returns to 0. It is low at all other times.
- R6: If `en_i` is low at the end of a pulse that is not the 257th, the current pulse finishes, `gs_clk_o` then stays low, and no line advance occurs.
- R7: If `en_i` is low during a gap cycle, the block goes idle. When `en_i` is next seen high in idle, `addr_o` becomes 0 and a new burst starts, with its first pulse high in the following cycle.
- R8: While `rst_ni` is low, `gs_clk_o`, `line_adv_o` and `eof_o` are 0 and `addr_o` is 0.
- R9: A burst whose 257th pulse completes always advances the line (R3, R4), even if `en_i` is low at that edge. The block then goes idle in the first gap cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable for the line scan |
| gap_len_i | input | GAP_W | Idle gap length in system clocks |
| gs_clk_o | output | 1 | Gated grayscale clock |
| addr_o | output | 5 | Current line address |
| line_adv_o | output | 1 | One-cycle strobe on each line step |
| eof_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench checks the off-by-one risks at the burst boundary: a 256- or 258-pulse burst, or a gap one clock longer or shorter than programmed, would appear as a one-cycle mismatch against the reference model. It changes the gap length between lines and programs a gap of zero, which catches designs that sample the length late or wait zero cycles. It drops the enable in three places: mid-burst, in the gap, and exactly at the edge that completes the 257th pulse. A design that cuts a pulse short, skips the final advance, or restarts at the old address fails there. A full frame plus wrap confirms that end-of-frame fires only on the 31-to-0 step.

// File: rtl/gs_pkg.sv
package gs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BURST = 2'd1,
    ST_GAP   = 2'd2
  } gs_state_e;
endpackage

// File: rtl/gs_phase_gen.sv
module gs_phase_gen #(
  parameter int DIV_N = 125
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic pulse_hi_o,
  output logic pulse_end_o
);
  localparam int PH_W = (DIV_N > 2) ? $clog2(DIV_N) : 1;
  localparam int HI   = DIV_N / 2;

  logic [PH_W-1:0] ph_q;

  assign pulse_end_o = run_i && (ph_q == PH_W'(DIV_N - 1));
  assign pulse_hi_o  = run_i && (ph_q < PH_W'(HI));

  // phase parks at 0 outside a burst so each burst starts aligned
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ph_q <= '0;
    else if (!run_i)      ph_q <= '0;
    else if (pulse_end_o) ph_q <= '0;
    else                  ph_q <= ph_q + PH_W'(1);
  end

  assert_phase_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q <= PH_W'(DIV_N - 1));
  assert_phase_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> ph_q == '0);
endmodule

// File: rtl/gs_line_ctrl.sv
module gs_line_ctrl
  import gs_pkg::*;
#(
  parameter int PULSES = 257,
  parameter int GAP_W  = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [GAP_W-1:0] gap_len_i,
  input  logic             pulse_end_i,
  output logic             run_o,
  output logic             start_o,
  output logic             line_done_o
);
  localparam int PC_W = $clog2(PULSES);

  gs_state_e        st_q, st_d;
  logic [PC_W-1:0]  pcnt_q;
  logic [GAP_W-1:0] gcnt_q, glen_q;
  logic             gap_end;

  assign run_o       = (st_q == ST_BURST);
  assign start_o     = (st_q == ST_IDLE) && en_i;
  assign line_done_o = run_o && pulse_end_i && (pcnt_q == PC_W'(PULSES - 1));
  assign gap_end     = (gcnt_q == glen_q - GAP_W'(1));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (en_i) st_d = ST_BURST;
      ST_BURST: begin
        if (line_done_o)             st_d = ST_GAP;   // completion wins over disable
        else if (pulse_end_i && !en_i) st_d = ST_IDLE;
      end
      ST_GAP: begin
        if (!en_i)        st_d = ST_IDLE;
        else if (gap_end) st_d = ST_BURST;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      pcnt_q <= '0;
      gcnt_q <= '0;
      glen_q <= GAP_W'(1);
    end else begin
      st_q <= st_d;
      if (st_q != ST_BURST)  pcnt_q <= '0;
      else if (pulse_end_i)  pcnt_q <= line_done_o ? '0 : pcnt_q + PC_W'(1);
      if (st_q != ST_GAP)    gcnt_q <= '0;
      else                   gcnt_q <= gcnt_q + GAP_W'(1);
      if (line_done_o)       glen_q <= (gap_len_i == '0) ? GAP_W'(1) : gap_len_i;
    end
  end

  assert_pulse_cnt_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcnt_q <= PC_W'(PULSES - 1));
  assert_gap_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_GAP) |-> (gcnt_q < glen_q));
  assert_gap_nonzero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glen_q != '0);
  assert_done_to_gap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_done_o |=> (st_q == ST_GAP));
endmodule

// File: rtl/gs_addr_ctr.sv
module gs_addr_ctr #(
  parameter int LINES  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              adv_o,
  output logic              eof_o
);
  logic [ADDR_W-1:0] addr_q;
  logic              adv_q, eof_q;
  logic              last;

  assign last   = (addr_q == ADDR_W'(LINES - 1));
  assign addr_o = addr_q;
  assign adv_o  = adv_q;
  assign eof_o  = eof_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      adv_q  <= 1'b0;
      eof_q  <= 1'b0;
    end else begin
      adv_q <= adv_i;
      eof_q <= adv_i && last;
      if (start_i)    addr_q <= '0;
      else if (adv_i) addr_q <= last ? '0 : addr_q + ADDR_W'(1);
    end
  end

  assert_addr_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_q <= ADDR_W'(LINES - 1));
  assert_adv_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_q |=> !adv_q);
  assert_eof_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_q |-> (adv_q && addr_q == '0));
endmodule

// File: rtl/gs_burst_seq.sv
module gs_burst_seq #(
  parameter int DIV_N  = 125,
  parameter int PULSES = 257,
  parameter int LINES  = 32,
  parameter int GAP_W  = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [GAP_W-1:0] gap_len_i,
  output logic             gs_clk_o,
  output logic [4:0]       addr_o,
  output logic             line_adv_o,
  output logic             eof_o
);
  localparam int ADDR_W = 5;

  logic run, start, line_done, pulse_hi, pulse_end;

  gs_phase_gen #(.DIV_N(DIV_N)) u_phase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run),
    .pulse_hi_o  (pulse_hi),
    .pulse_end_o (pulse_end)
  );

  gs_line_ctrl #(.PULSES(PULSES), .GAP_W(GAP_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .gap_len_i   (gap_len_i),
    .pulse_end_i (pulse_end),
    .run_o       (run),
    .start_o     (start),
    .line_done_o (line_done)
  );

  gs_addr_ctr #(.LINES(LINES), .ADDR_W(ADDR_W)) u_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .adv_i   (line_done),
    .addr_o  (addr_o),
    .adv_o   (line_adv_o),
    .eof_o   (eof_o)
  );

  assign gs_clk_o = pulse_hi;

  assert_addr_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gs_clk_o && $past(gs_clk_o)) |-> $stable(addr_o));
  assert_adv_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_adv_o |-> !gs_clk_o);
  assert_stop_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run) |-> !gs_clk_o);
endmodule

// File: tb/sim_gs_burst_seq.sv
module sim_gs_burst_seq;
  localparam int N     = 4;
  localparam int NP    = 257;
  localparam int BLEN  = NP * N;
  localparam int GW    = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [GW-1:0] gap = GW'(10);
  logic          gs, adv, eof;
  logic [4:0]    addr;

  int checks = 0, failures = 0, cycles = 0;
  // reference model
  int m_run = 0, m_t = 0, m_g = 1, m_addr = 0, m_adv = 0, m_eof = 0;
  // monitors
  int adv_cnt = 0, eof_cnt = 0, rise_cnt = 0, clean = 0, prev_gs = 0;

  always #2 clk = ~clk;

  gs_burst_seq #(.DIV_N(N), .PULSES(NP), .LINES(32), .GAP_W(GW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .gap_len_i(gap),
    .gs_clk_o(gs), .addr_o(addr), .line_adv_o(adv), .eof_o(eof)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cycles, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_t = 0; m_addr = 0; m_adv = 0; m_eof = 0; m_g = 1;
    end else begin
      m_adv = 0; m_eof = 0;
      if (m_run == 0) begin
        if (en) begin m_run = 1; m_t = 0; m_addr = 0; end
      end else if (m_t < BLEN) begin
        if (m_t % N == N - 1) begin
          if (m_t == BLEN - 1) begin
            m_t = BLEN; m_g = (gap == 0) ? 1 : int'(gap);
            m_addr = (m_addr + 1) % 32; m_adv = 1; m_eof = (m_addr == 0);
          end else if (!en) m_run = 0;
          else m_t++;
        end else m_t++;
      end else begin
        if (!en) m_run = 0;
        else if (m_t == BLEN + m_g - 1) m_t = 0;
        else m_t++;
      end
    end
  end

  always @(negedge clk) begin
    int exp_gs;
    cycles++;
    if (rst_n) begin
      exp_gs = (m_run != 0 && m_t < BLEN && (m_t % N) < N / 2) ? 1 : 0;
      chk((m_run == 0) ? "R6" : (m_t < BLEN ? "R1" : "R2"), int'(gs), exp_gs);
      chk("R3", int'(addr), m_addr);
      chk("R4", int'(adv), m_adv);
      chk("R5", int'(eof), m_eof);
      if (gs && !prev_gs) rise_cnt++;
      prev_gs = gs;
      if (!en) clean = 0;
      if (adv) begin
        if (clean != 0) chk("R1 pulse count", rise_cnt, NP);
        rise_cnt = 0; clean = 1; adv_cnt++;
      end
      if (eof) eof_cnt++;
    end
    if (cycles > 190000) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wait_adv(input int k);
    int target = adv_cnt + k;
    while (adv_cnt < target) @(negedge clk);
  endtask

  initial begin
    int a0, e0;
    repeat (3) @(negedge clk);
    chk("R8 gs", int'(gs), 0);
    chk("R8 addr", int'(addr), 0);
    chk("R8 adv", int'(adv), 0);
    chk("R8 eof", int'(eof), 0);
    rst_n = 1'b1;
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R7 first pulse high", int'(gs), 1);
    wait_adv(12);
    gap = GW'(3);
    wait_adv(10);
    gap = GW'(0);
    wait_adv(12);
    chk("R5 one eof per frame", eof_cnt, 1);
    gap = GW'(10);
    // R6: drop enable mid-burst
    repeat (301) @(negedge clk);
    en = 1'b0;
    a0 = adv_cnt;
    repeat (60) @(negedge clk);
    chk("R6 no advance", adv_cnt, a0);
    chk("R6 low", int'(gs), 0);
    en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R7 restart addr", int'(addr), 0);
    chk("R7 restart pulse", int'(gs), 1);
    // R7: drop enable inside a gap
    wait_adv(1);
    en = 1'b0;
    repeat (30) @(negedge clk);
    chk("R7 idle low", int'(gs), 0);
    en = 1'b1;
    wait_adv(2);
    // R9: enable low exactly at the completing edge
    while (!(m_run != 0 && m_t == BLEN - 1)) @(negedge clk);
    a0 = adv_cnt;
    e0 = int'(addr);
    en = 1'b0;
    repeat (20) @(negedge clk);
    chk("R9 final advance", adv_cnt, a0 + 1);
    chk("R9 addr stepped", int'(addr), (e0 + 1) % 32);
    en = 1'b1;
    wait_adv(1);
    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule